// File: doc/BRIEF.md
# PCM Sample Playback Voice

One channel of a wavetable voice. A fixed-point address accumulator (16 integer bits and a parameterised fraction) walks through a 64 KB byte-wide sample memory. On each sample-rate tick the voice fetches one 8-bit sign-magnitude sample. It scales the magnitude by an 8-bit envelope level and by two 4-bit pan gains, and it drives signed left and right results. The tick runs at a fixed 32552 Hz in the target system, whatever the video standard. The sample memory sits outside the block and is reached through a synchronous read port: the data for a read strobe arrives one clock later.

The byte value 0xFF never plays. It marks the end of a waveform. When looping is enabled, the voice reloads its accumulator from the loop start and fetches the loop-start sample inside the same slot. This costs one extra clock of latency but no extra tick. If the loop start also holds the marker, the slot is silent. A small byte-wide register port sets the envelope, the pan gains, the frequency step, the loop start and the control bits. Several such voices are mixed outside this block.

Top module: `pcm_voice`

## Requirements
- R1: Register writes take effect on the next clock. The register addresses are: 0 envelope, 1 pan, 2 and 3 for the step low and high bytes, 4 and 5 for the loop start low and high bytes, and 6 control, where bit 7 is key-on and bit 6 is loop enable. After reset every register and output is zero and `mem_rd_o` is low.
- R2: When key-on goes from 0 to 1, the accumulator loads the loop start as its integer part with a zero fraction. The first slot that follows reads the loop-start address.
- R3: A tick while the voice is keyed on and idle raises `mem_rd_o` in the same cycle, with the accumulator's integer part on `mem_addr_o`. For a non-marker sample, `valid_o` pulses for one cycle two clocks after the tick cycle. A normal slot makes exactly one read.
- R4: The pan low nibble is the left gain and the high nibble is the right gain. Sample bit 7 set means positive, and bits 6..0 are the magnitude. Each output equals (magnitude × envelope × gain) >> 5, negated when bit 7 is clear.
- R5: After each played slot the accumulator adds the zero-extended 16-bit step, which is in 5.11 format. The integer part wraps modulo 65536.
- R6: With loop enable set, a 0xFF sample reloads the accumulator from the loop start and issues a second read of the loop-start address in the following cycle. That sample is played with `valid_o` one clock later than in R3, and the step is then added to the loop-start value.
- R7: If the reloaded loop-start sample is also 0xFF, `valid_o` pulses with both outputs zero. The accumulator stays at the loop start.
- R8: With loop enable clear, a 0xFF sample gives a zero output with a `valid_o` pulse, and the accumulator does not advance.
- R9: While key-on is low, both outputs are zero and `valid_o` is low from the clock after key-on falls. Ticks are ignored and `mem_rd_o` stays low.
- R10: Between slots the outputs hold the value of the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| tick_i | input | 1 | Sample-rate slot start |
| mem_rd_o | output | 1 | Sample memory read strobe |
| mem_addr_o | output | 16 | Sample memory byte address |
| mem_data_i | input | 8 | Sample memory read data, one clock after the strobe |
| left_o | output | 15 | Signed left result |
| right_o | output | 15 | Signed right result |
| valid_o | output | 1 | One-cycle pulse when a slot result is written |

## Verification
The bench builds the voice with its default 11 fractional address bits and a right shift of 5. With these values a 1.5 step carries out of the fraction within two slots, and a 1.0 step starting at 0xFFFF reaches the integer wrap in one slot. The largest step of just under 32 is also exercised. The sample memory holds single and back-to-back end markers, so that the bench sees the reload read, the silent double-marker slot and the non-looping stall. It also drives pan settings with a zero nibble and extreme envelope values, so that both sign directions and a muted side appear on the outputs.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int MAG_W  = 7;
  localparam int ENV_W  = 8;
  localparam int PAN_W  = 4;

  localparam logic [2:0] A_ENV     = 3'd0;
  localparam logic [2:0] A_PAN     = 3'd1;
  localparam logic [2:0] A_STEP_LO = 3'd2;
  localparam logic [2:0] A_STEP_HI = 3'd3;
  localparam logic [2:0] A_LOOP_LO = 3'd4;
  localparam logic [2:0] A_LOOP_HI = 3'd5;
  localparam logic [2:0] A_CTRL    = 3'd6;

  localparam int CTRL_KEY_BIT  = 7;
  localparam int CTRL_LOOP_BIT = 6;

  localparam logic [BYTE_W-1:0] END_MARK = 8'hFF;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_RELOAD
  } fetch_st_e;
endpackage

// File: rtl/pcm_voice_regs.sv
module pcm_voice_regs
  import pcm_voice_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [ENV_W-1:0]  env_o,
  output logic [BYTE_W-1:0] pan_o,
  output logic [WORD_W-1:0] step_o,
  output logic [WORD_W-1:0] loop_o,
  output logic              key_on_o,
  output logic              loop_en_o,
  output logic              key_rise_o
);
  logic key_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_o     <= '0;
      pan_o     <= '0;
      step_o    <= '0;
      loop_o    <= '0;
      key_on_o  <= 1'b0;
      loop_en_o <= 1'b0;
      key_d     <= 1'b0;
    end else begin
      key_d <= key_on_o;
      if (we_i) begin
        case (addr_i)
          A_ENV:     env_o                  <= wdata_i;
          A_PAN:     pan_o                  <= wdata_i;
          A_STEP_LO: step_o[BYTE_W-1:0]     <= wdata_i;
          A_STEP_HI: step_o[WORD_W-1:BYTE_W] <= wdata_i;
          A_LOOP_LO: loop_o[BYTE_W-1:0]     <= wdata_i;
          A_LOOP_HI: loop_o[WORD_W-1:BYTE_W] <= wdata_i;
          A_CTRL: begin
            key_on_o  <= wdata_i[CTRL_KEY_BIT];
            loop_en_o <= wdata_i[CTRL_LOOP_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  assign key_rise_o = key_on_o & ~key_d;
endmodule

// File: rtl/pcm_voice_fetch.sv
module pcm_voice_fetch
  import pcm_voice_pkg::*;
#(
  parameter int FRAC_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              key_on_i,
  input  logic              key_rise_i,
  input  logic              loop_en_i,
  input  logic [WORD_W-1:0] step_i,
  input  logic [WORD_W-1:0] loop_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              load_o,
  output logic              silent_o
);
  localparam int ACC_W = WORD_W + FRAC_W;

  fetch_st_e        st_q, st_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] step_ext, loop_full;
  logic             is_mark;

  assign step_ext  = ACC_W'(step_i);
  assign loop_full = {loop_i, {FRAC_W{1'b0}}};
  assign is_mark   = (mem_data_i == END_MARK);

  always_comb begin
    st_d       = st_q;
    acc_d      = acc_q;
    mem_rd_o   = 1'b0;
    mem_addr_o = acc_q[ACC_W-1:FRAC_W];
    load_o     = 1'b0;
    silent_o   = 1'b0;
    if (!key_on_i) begin
      st_d = S_IDLE;
    end else if (key_rise_i) begin
      st_d  = S_IDLE;
      acc_d = loop_full;
    end else begin
      case (st_q)
        S_IDLE: if (tick_i) begin
          mem_rd_o = 1'b1;
          st_d     = S_FETCH;
        end
        S_FETCH: begin
          if (is_mark && loop_en_i) begin
            // reload in the same slot
            mem_rd_o   = 1'b1;
            mem_addr_o = loop_i;
            acc_d      = loop_full;
            st_d       = S_RELOAD;
          end else if (is_mark) begin
            silent_o = 1'b1;
            st_d     = S_IDLE;
          end else begin
            load_o = 1'b1;
            acc_d  = acc_q + step_ext;
            st_d   = S_IDLE;
          end
        end
        S_RELOAD: begin
          st_d = S_IDLE;
          if (is_mark) begin
            silent_o = 1'b1;
          end else begin
            load_o = 1'b1;
            acc_d  = acc_q + step_ext;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      acc_q <= '0;
    end else begin
      st_q  <= st_d;
      acc_q <= acc_d;
    end
  end

  // R2
  key_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rise_i |=> acc_q == {$past(loop_i), {FRAC_W{1'b0}}});

  // R6
  mark_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FETCH && key_on_i && !key_rise_i && loop_en_i && mem_data_i == END_MARK)
    |=> (st_q == S_RELOAD && acc_q == {$past(loop_i), {FRAC_W{1'b0}}}));

  // R8
  no_loop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FETCH && key_on_i && !key_rise_i && !loop_en_i && mem_data_i == END_MARK)
    |=> (st_q == S_IDLE && $stable(acc_q)));
endmodule

// File: rtl/pcm_voice_scale.sv
module pcm_voice_scale
  import pcm_voice_pkg::*;
#(
  parameter int SHIFT = 5,
  localparam int PROD_W = MAG_W + ENV_W + PAN_W,
  localparam int SC_W   = PROD_W - SHIFT,
  localparam int OUT_W  = SC_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    key_on_i,
  input  logic                    load_i,
  input  logic                    silent_i,
  input  logic [BYTE_W-1:0]       sample_i,
  input  logic [ENV_W-1:0]        env_i,
  input  logic [BYTE_W-1:0]       pan_i,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o,
  output logic                    valid_o
);
  localparam int MAX_OUT = (((1 << MAG_W) - 1) * ((1 << ENV_W) - 1) * ((1 << PAN_W) - 1)) >> SHIFT;

  logic signed [OUT_W-1:0] lane [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    logic [PAN_W-1:0]  gain;
    logic [PROD_W-1:0] prod;
    logic [SC_W-1:0]   mag_sc;
    assign gain   = pan_i[ch*PAN_W +: PAN_W];
    assign prod   = PROD_W'(sample_i[MAG_W-1:0]) * PROD_W'(env_i) * PROD_W'(gain);
    assign mag_sc = prod[PROD_W-1:SHIFT];
    assign lane[ch] = sample_i[MAG_W] ? $signed({1'b0, mag_sc}) : -$signed({1'b0, mag_sc});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else if (!key_on_i) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i | silent_i;
      if (load_i) begin
        left_o  <= lane[0];
        right_o <= lane[1];
      end else if (silent_i) begin
        left_o  <= '0;
        right_o <= '0;
      end
    end
  end

  // R9
  keyoff_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_on_i |=> (left_o == '0 && right_o == '0 && !valid_o));

  // R4
  out_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(left_o) <= MAX_OUT && int'(left_o) >= -MAX_OUT &&
                 int'(right_o) <= MAX_OUT && int'(right_o) >= -MAX_OUT));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_on_i && !load_i && !silent_i) |=> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/pcm_voice.sv
module pcm_voice
  import pcm_voice_pkg::*;
#(
  parameter int FRAC_W = 11,
  parameter int SHIFT  = 5,
  localparam int OUT_W = MAG_W + ENV_W + PAN_W - SHIFT + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [2:0]              reg_addr_i,
  input  logic [BYTE_W-1:0]       reg_wdata_i,
  input  logic                    tick_i,
  output logic                    mem_rd_o,
  output logic [WORD_W-1:0]       mem_addr_o,
  input  logic [BYTE_W-1:0]       mem_data_i,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o,
  output logic                    valid_o
);
  logic [ENV_W-1:0]  env;
  logic [BYTE_W-1:0] pan;
  logic [WORD_W-1:0] step, loop_start;
  logic              key_on, loop_en, key_rise;
  logic              load, silent;

  pcm_voice_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .env_o      (env),
    .pan_o      (pan),
    .step_o     (step),
    .loop_o     (loop_start),
    .key_on_o   (key_on),
    .loop_en_o  (loop_en),
    .key_rise_o (key_rise)
  );

  pcm_voice_fetch #(.FRAC_W(FRAC_W)) i_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .key_on_i   (key_on),
    .key_rise_i (key_rise),
    .loop_en_i  (loop_en),
    .step_i     (step),
    .loop_i     (loop_start),
    .mem_data_i (mem_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .load_o     (load),
    .silent_o   (silent)
  );

  pcm_voice_scale #(.SHIFT(SHIFT)) i_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_on_i (key_on),
    .load_i   (load),
    .silent_i (silent),
    .sample_i (mem_data_i),
    .env_i    (env),
    .pan_i    (pan),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );
endmodule

// File: tb/test_pcm_voice.sv
module test_pcm_voice;
  localparam int FRAC = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [2:0]        waddr = '0;
  logic [7:0]        wdata = '0;
  logic              tick = 1'b0;
  logic              mem_rd_o;
  logic [15:0]       mem_addr_o;
  logic [7:0]        mem_q = '0;
  logic signed [14:0] left_o, right_o;
  logic              valid_o;

  int total = 0;
  int bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  // reference model state
  logic [26:0] macc = '0;
  int m_env = 0, m_pan = 0, m_step = 0, m_loop = 0;
  bit m_key = 0, m_lp = 0;
  int exp_l = 0, exp_r = 0;
  bit exp_v = 0;

  logic [7:0] smem [int];

  always #2 clk = ~clk;

  pcm_voice i_pcm_voice (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (waddr),
    .reg_wdata_i (wdata),
    .tick_i      (tick),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_q),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );

  function automatic logic [7:0] rd(int a);
    if (smem.exists(a)) return smem[a];
    return 8'h00;
  endfunction

  function automatic int scaled(logic [7:0] s, int gain);
    int p;
    p = (int'(s[6:0]) * m_env * gain) >> 5;
    return s[7] ? p : -p;
  endfunction

  always @(posedge clk) if (mem_rd_o) mem_q <= rd(int'(mem_addr_o));

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (chk_en && !done) begin
      chk(int'(left_o) == exp_l, "R4 R10 left per clock", int'(left_o), exp_l);
      chk(int'(right_o) == exp_r, "R4 R10 right per clock", int'(right_o), exp_r);
      chk(valid_o == exp_v, "R3 valid per clock", int'(valid_o), int'(exp_v));
    end
  end

  task automatic write_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    case (a)
      3'd0: m_env = d;
      3'd1: m_pan = d;
      3'd2: m_step = (m_step & 32'hFF00) | d;
      3'd3: m_step = (m_step & 32'h00FF) | (int'(d) << 8);
      3'd4: m_loop = (m_loop & 32'hFF00) | d;
      3'd5: m_loop = (m_loop & 32'h00FF) | (int'(d) << 8);
      3'd6: begin
        if (d[7] && !m_key) macc = 27'(m_loop) << FRAC;
        m_key = d[7];
        m_lp  = d[6];
      end
      default: ;
    endcase
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic key_off();
    write_reg(3'd6, 8'h00);
    @(negedge clk);
    exp_l = 0; exp_r = 0; exp_v = 0;
    #1;
    chk(left_o == 0 && right_o == 0, "R9 outputs zero after key-off", int'(left_o), 0);
  endtask

  task automatic set_out(logic [7:0] s);
    exp_l = scaled(s, m_pan & 15);
    exp_r = scaled(s, (m_pan >> 4) & 15);
    exp_v = 1'b1;
  endtask

  task automatic run_slot(string tag);
    int a;
    logic [7:0] s, s2;
    @(negedge clk);
    tick = 1'b1;
    #1;
    a = int'(macc >> FRAC);
    chk(mem_rd_o == 1'b1, {tag, " R3 read strobe"}, int'(mem_rd_o), 1);
    chk(int'(mem_addr_o) == a, {tag, " slot address"}, int'(mem_addr_o), a);
    s = rd(a);
    @(negedge clk);
    tick = 1'b0;
    #1;
    if (s == 8'hFF && m_lp) begin
      chk(mem_rd_o && int'(mem_addr_o) == m_loop, "R6 reload address", int'(mem_addr_o), m_loop);
      s2 = rd(m_loop);
      macc = 27'(m_loop) << FRAC;
      @(negedge clk);
      @(negedge clk);
      if (s2 == 8'hFF) begin
        exp_l = 0; exp_r = 0; exp_v = 1'b1;
        #1;
        chk(valid_o && left_o == 0 && right_o == 0, "R7 double marker silent", int'(left_o), 0);
      end else begin
        set_out(s2);
        macc = macc + 27'(m_step);
        #1;
        chk(int'(left_o) == exp_l, "R6 loop sample played", int'(left_o), exp_l);
      end
    end else begin
      chk(mem_rd_o == 1'b0, "R3 single read per slot", int'(mem_rd_o), 0);
      @(negedge clk);
      if (s == 8'hFF) begin
        exp_l = 0; exp_r = 0; exp_v = 1'b1;
        #1;
        chk(valid_o && left_o == 0 && right_o == 0, "R8 marker without loop silent", int'(left_o), 0);
      end else begin
        set_out(s);
        macc = macc + 27'(m_step);
        #1;
        chk(int'(right_o) == exp_r, {tag, " R4 scaled right"}, int'(right_o), exp_r);
      end
    end
    @(negedge clk);
    exp_v = 1'b0;
  endtask

  initial begin
    smem[32'h100] = 8'h85; smem[32'h101] = 8'h12; smem[32'h102] = 8'h7F;
    smem[32'h103] = 8'hC0; smem[32'h104] = 8'h00; smem[32'h105] = 8'h80;
    smem[32'h106] = 8'hFF;
    smem[32'h200] = 8'hFF;
    smem[32'h300] = 8'h90; smem[32'h301] = 8'hFF;
    smem[32'hFFFF] = 8'hC5; smem[32'h0000] = 8'h01; smem[32'h0001] = 8'h83;
    smem[32'h120] = 8'hAA; smem[32'h140] = 8'h3C;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(left_o == 0 && right_o == 0 && !valid_o, "R1 reset outputs", int'(left_o), 0);
    chk(mem_rd_o == 1'b0, "R1 reset read strobe", int'(mem_rd_o), 0);
    chk_en = 1'b1;

    // looping playback with fractional step 1.5
    write_reg(3'd0, 8'h80);
    write_reg(3'd1, 8'hF3);
    write_reg(3'd2, 8'h00);
    write_reg(3'd3, 8'h0C);
    write_reg(3'd4, 8'h00);
    write_reg(3'd5, 8'h01);
    write_reg(3'd6, 8'hC0);
    run_slot("R2 first slot at loop start");
    for (int i = 0; i < 6; i++) run_slot("R5 fractional step");

    // env and pan change, zero right gain
    write_reg(3'd0, 8'hFF);
    write_reg(3'd1, 8'h0F);
    for (int i = 0; i < 3; i++) run_slot("R1 env and pan write");

    // double marker at loop start
    key_off();
    write_reg(3'd5, 8'h02);
    write_reg(3'd6, 8'hC0);
    run_slot("R7 first");
    run_slot("R7 accumulator held at loop start");

    // marker with loop disabled
    key_off();
    write_reg(3'd3, 8'h08);
    write_reg(3'd5, 8'h03);
    write_reg(3'd6, 8'h80);
    run_slot("R8 before marker");
    run_slot("R8 at marker");
    run_slot("R8 accumulator held");

    // integer wrap
    key_off();
    write_reg(3'd4, 8'hFF);
    write_reg(3'd5, 8'hFF);
    write_reg(3'd1, 8'h5A);
    write_reg(3'd6, 8'hC0);
    for (int i = 0; i < 3; i++) run_slot("R5 wrap");

    // largest step
    key_off();
    write_reg(3'd2, 8'hFF);
    write_reg(3'd3, 8'hFF);
    write_reg(3'd4, 8'h00);
    write_reg(3'd5, 8'h01);
    write_reg(3'd0, 8'h40);
    write_reg(3'd1, 8'h88);
    write_reg(3'd6, 8'hC0);
    for (int i = 0; i < 3; i++) run_slot("R5 large step");

    // key-off: ticks ignored
    key_off();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tick = 1'b1;
      #1;
      chk(mem_rd_o == 1'b0, "R9 tick ignored while keyed off", int'(mem_rd_o), 0);
      @(negedge clk);
      tick = 1'b0;
    end
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule